// File: doc/BRIEF.md
# Quiet-Gap Broadcast Bus Access Controller

This block decides when one terminal on a shared, time-multiplexed broadcast bus may start driving the bus. No master grants access. The terminal watches a bus-activity input and starts only after the bus has been quiet for a terminal-specific gap. Once it has transmitted, it holds itself off for a round so that every other terminal gets a turn. Three programmable timers make this fair. A transmit interval timer measures time from the start of the terminal's own transmission. A synchronization gap timer needs a long, unbroken quiet stretch before the terminal re-arms. A terminal gap timer is set differently on each terminal and needs a shorter unbroken quiet stretch before the terminal may start.

The user raises `tx_req` for one or more cycles, and the request is held until it is served. `msg_ready` tells the block that the message is ready to send. While `tx_en` is high the attached transmitter drives the bus. The transmitter pulses `tx_done` when the message ends. The controller has five states: idle (armed), waiting for the terminal gap, transmitting, holding off on the interval timer, and waiting for the synchronization gap. It has no data path, so every pin is a plain level or pulse with no handshake.

Top module: `bcast_access_ctrl`

## Requirements
- R1: While reset is asserted, `tx_en` is low. After reset the controller is armed, with all timers cleared and no request pending.
- R2: `tx_en` rises only on a clock edge where `bus_busy` was sampled low.
- R3: The request is sampled on clock edge e, the controller is armed, the bus is quiet and `msg_ready` is high. Then `tx_en` is first high right after edge e + `cfg_tg` + 2.
- R4: Bus activity sampled while the controller waits out the terminal gap stops the attempt with no transmission, and the request stays pending. If the last busy edge is b and the bus stays quiet afterwards, `tx_en` rises right after edge b + `cfg_tg` + 2.
- R5: The terminal gap may have run out while `msg_ready` is low. In that case `tx_en` stays low and rises on the first edge that samples `msg_ready` high.
- R6: `tx_en` stays high until `tx_done` is sampled high, and it is low right after that edge.
- R7: A transmission starts after edge s and `tx_done` is sampled at edge d. With a request pending and a quiet bus, the next transmission starts after edge max(d+1, s+`cfg_ti`+1) + `cfg_sg` + `cfg_tg` + 3. Consecutive starts are therefore always more than `cfg_ti` cycles apart.
- R8: Bus activity during the synchronization gap restarts that gap. If the last busy edge b falls at or after the end of the hold-off, the next start follows edge b + `cfg_sg` + `cfg_tg` + 3.
- R9: A request raised while a transmission is running, or during hold-off, is kept and is served in the next round.
- R10: With no request pending, `tx_en` stays low however long the bus stays quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_busy | input | 1 | Bus activity sensed this cycle |
| tx_req | input | 1 | Request to transmit; held pending until served |
| msg_ready | input | 1 | Message is ready to send |
| tx_done | input | 1 | Current transmission has ended |
| cfg_ti | input | TW | Transmit interval, in clocks from the start of the terminal's own transmission |
| cfg_sg | input | TW | Synchronization gap in quiet clocks; set larger than any terminal gap |
| cfg_tg | input | TW | Terminal gap in quiet clocks; unique per terminal |
| tx_en | output | 1 | Permission to drive the bus |

## Verification
The hardest cases to reach from the ports are the two quiet-time restarts. One is bus activity that lands inside the few cycles of the terminal gap. The other is activity that straddles the end of hold-off and restarts the synchronization gap. The bench reaches both by working out, for each configuration, the exact edge at which the controller enters each wait state. It uses the start and end edges of the previous transmission to do this, and then places a single busy edge inside that window. It sweeps every small combination of the three timers, including a zero terminal gap, where the gap window is only one edge wide.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_SYNC = 3'd1,
    ST_WAIT_GAP  = 3'd2,
    ST_TRANSMIT  = 3'd3,
    ST_HOLDOFF   = 3'd4
  } bac_state_e;
endpackage

// File: rtl/bac_quiet_timer.sv
// Counts consecutive quiet clocks while enabled; any activity restarts it.
module bac_quiet_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          busy,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || busy)  cnt <= '0;
    else if (cnt < limit)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt >= limit);
endmodule

// File: rtl/bac_interval_timer.sv
// Loaded when the terminal's own transmission starts; expires at zero.
module bac_interval_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] load,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= load;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/bcast_access_ctrl.sv
module bcast_access_ctrl
  import bac_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_busy,
  input  logic          tx_req,
  input  logic          msg_ready,
  input  logic          tx_done,
  input  logic [TW-1:0] cfg_ti,
  input  logic [TW-1:0] cfg_sg,
  input  logic [TW-1:0] cfg_tg,
  output logic          tx_en
);
  localparam int NQ      = 2;
  localparam int QI_SYNC = 0;
  localparam int QI_GAP  = 1;

  bac_state_e    st, st_n;
  logic          pend;
  logic          start;
  logic          ivl_expired;
  logic [NQ-1:0] q_run;
  logic [NQ-1:0] q_done;
  logic [TW-1:0] q_lim [NQ];

  assign q_run[QI_SYNC] = (st == ST_WAIT_SYNC);
  assign q_run[QI_GAP]  = (st == ST_WAIT_GAP);
  assign q_lim[QI_SYNC] = cfg_sg;
  assign q_lim[QI_GAP]  = cfg_tg;

  for (genvar g = 0; g < NQ; g++) begin : g_quiet
    bac_quiet_timer #(.TW(TW)) u_quiet (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (q_run[g]),
      .busy  (bus_busy),
      .limit (q_lim[g]),
      .done  (q_done[g])
    );
  end

  bac_interval_timer #(.TW(TW)) u_ivl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .load    (cfg_ti),
    .expired (ivl_expired)
  );

  always_comb begin
    st_n  = st;
    start = 1'b0;
    unique case (st)
      ST_IDLE:      if (pend && !bus_busy) st_n = ST_WAIT_GAP;
      ST_WAIT_GAP: begin
        if (bus_busy) begin
          st_n = ST_IDLE;
        end else if (q_done[QI_GAP] && msg_ready) begin
          st_n  = ST_TRANSMIT;
          start = 1'b1;
        end
      end
      ST_TRANSMIT:  if (tx_done) st_n = ST_HOLDOFF;
      ST_HOLDOFF:   if (ivl_expired) st_n = ST_WAIT_SYNC;
      ST_WAIT_SYNC: if (q_done[QI_SYNC]) st_n = ST_IDLE;
      default:      st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pend <= 1'b0;
    end else begin
      st   <= st_n;
      pend <= (pend & ~start) | tx_req;
    end
  end

  assign tx_en = (st == ST_TRANSMIT);
endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_busy,
  input logic          msg_ready,
  input logic          tx_done,
  input logic [TW-1:0] cfg_ti,
  input logic [TW-1:0] cfg_tg,
  input logic          tx_en
);
  logic [31:0] quiet_run;
  logic [31:0] since_tx;
  logic        seen_tx;
  logic        tx_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_run <= '0;
      since_tx  <= '0;
      seen_tx   <= 1'b0;
      tx_en_q   <= 1'b0;
    end else begin
      tx_en_q   <= tx_en;
      quiet_run <= bus_busy ? '0 : ((quiet_run == '1) ? quiet_run : quiet_run + 1);
      if (tx_en && !tx_en_q) begin
        since_tx <= 32'd1;
        seen_tx  <= 1'b1;
      end else if (since_tx != '1) begin
        since_tx <= since_tx + 1;
      end
    end
  end

  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!tx_en) else $error("tx_en high in reset");

  assert_start_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> !$past(bus_busy));

  assert_gap_elapsed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (quiet_run > 32'(cfg_tg)));

  assert_ready_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(msg_ready));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tx_done) |=> tx_en);

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_done) |=> !tx_en);

  assert_interval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tx_en_q && seen_tx) |-> (since_tx > 32'(cfg_ti)));
endmodule

bind bcast_access_ctrl bac_checker #(.TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_busy  (bus_busy),
  .msg_ready (msg_ready),
  .tx_done   (tx_done),
  .cfg_ti    (cfg_ti),
  .cfg_tg    (cfg_tg),
  .tx_en     (tx_en)
);

// File: tb/bcast_access_ctrl_tb.sv
module bcast_access_ctrl_tb;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_busy = 1'b0, tx_req = 1'b0, msg_ready = 1'b0, tx_done = 1'b0;
  logic [TW-1:0] cfg_ti = '0, cfg_sg = '0, cfg_tg = '0;
  logic          tx_en;
  int            cyc = 0, errs = 0, checks = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcast_access_ctrl #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .tx_req(tx_req),
    .msg_ready(msg_ready), .tx_done(tx_done), .cfg_ti(cfg_ti),
    .cfg_sg(cfg_sg), .cfg_tg(cfg_tg), .tx_en(tx_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s ti=%0d sg=%0d tg=%0d: actual=%0d expected=%0d",
               req, cfg_ti, cfg_sg, cfg_tg, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic step_until(input int target);
    while (cyc < target) step();
  endtask

  task automatic wait_tx(output int at);
    int n = 0;
    while (!tx_en && n < 400) begin step(); n++; end
    at = tx_en ? cyc : -1;
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_cfg(input int ti, input int sg, input int tg);
    int c, t, d, x, b, g, e;
    cfg_ti = TW'(ti); cfg_sg = TW'(sg); cfg_tg = TW'(tg);
    bus_busy = 0; tx_req = 0; msg_ready = 0; tx_done = 0;
    rst_n = 0;
    repeat (3) step();
    chk(tx_en == 0, "R1 reset", int'(tx_en), 0);
    rst_n = 1;
    repeat (6) step();
    chk(tx_en == 0, "R10 no request", int'(tx_en), 0);

    // R3: first request from the armed state
    msg_ready = 1;
    c = cyc; tx_req = 1; step(); tx_req = 0;
    wait_tx(t); e = c + tg + 3;
    chk(t == e, "R3 gap start", t, e);

    // R9 request during transmission, R6 hold and release
    tx_req = 1; step(); tx_req = 0; step();
    chk(tx_en == 1, "R6 hold", int'(tx_en), 1);
    d = cyc + 1; tx_done = 1; step(); tx_done = 0;
    chk(tx_en == 0, "R6 release", int'(tx_en), 0);
    wait_tx(c); e = imax(d + 1, t + ti + 1) + sg + tg + 3;
    chk(c == e, "R7 R9 next round", c, e);
    t = c;

    // R8: activity straddling the end of hold-off
    d = cyc + 1; tx_req = 1; tx_done = 1; step(); tx_req = 0; tx_done = 0;
    bus_busy = 1;
    b = imax(d, t + ti) + 3;
    step_until(b); bus_busy = 0;
    wait_tx(c); e = b + sg + tg + 3;
    chk(c == e, "R8 sync restart", c, e);
    t = c;

    // R4: activity inside the terminal gap
    d = cyc + 1; tx_req = 1; tx_done = 1; step(); tx_req = 0; tx_done = 0;
    x = imax(d + 1, t + ti + 1);
    b = x + sg + 3;
    step_until(b - 1); bus_busy = 1; step(); bus_busy = 0;
    chk(tx_en == 0, "R4 aborted", int'(tx_en), 0);
    wait_tx(c); e = b + tg + 2;
    chk(c == e, "R4 retry", c, e);
    t = c;

    // R5: message not ready when the gap runs out
    d = cyc + 1; tx_req = 1; tx_done = 1; msg_ready = 0; step(); tx_req = 0; tx_done = 0;
    x = imax(d + 1, t + ti + 1);
    g = x + sg + tg + 3;
    step_until(g + 3);
    chk(tx_en == 0, "R5 held", int'(tx_en), 0);
    msg_ready = 1; step();
    chk(tx_en == 1 && cyc == g + 4, "R5 release", int'(tx_en), 1);
    tx_done = 1; step(); tx_done = 0;
    repeat (2) step();
  endtask

  initial begin
    step();
    for (int tg = 0; tg <= 3; tg++)
      for (int sg = tg + 1; sg <= tg + 3; sg++)
        for (int k = 0; k < 3; k++)
          run_cfg((k == 0) ? 1 : ((k == 1) ? 5 : 14), sg, tg);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule